// File: doc/BRIEF.md
# Pausable Up/Down Counter-Timer

This block is a general-purpose 24-bit counter-timer with two modes. In edge-counting mode, a counter steps once for every event from the selected source. In pulse-train mode, the same events time an output waveform with separately programmed low and high lengths. A gate input acts as a level-sensitive pause. While the gate sits at the programmed pause level, counting or waveform timing is frozen, and it resumes from the exact same point when the gate leaves that level.

There are three event sources. The first is a fast timebase strobe. The second is a slow strobe derived inside the block from every 200th fast strobe. The third is the rising edge of an asynchronous external input. The count direction comes either from a control bit or from a hardware up/down line. The asynchronous inputs (external source, gate and up/down line) are resynchronised before use.

Software programs the block through a plain synchronous write port with four word addresses: 0 control, 1 high length, 2 low length, 3 count load. The current count and a sticky wrap flag are always visible on output pins.

Top module: `pause_ctr_timer`

## Requirements
- R1: After reset, in edge mode (control bit1 = 0) with arm set (bit0 = 1) and the gate unused, each selected event increments `count_o` by 1 when control bit6 = 1. The new value is visible after the clock edge at which the event is seen.
- R2: Counting goes down instead when bit6 = 0. When bit5 = 1, the direction comes from the synchronised `updown_in` line instead (1 = up).
- R3: The count wraps modulo 2^24 in both directions. A wrap sets `tc_o`. `tc_o` stays set until a control write with bit8 = 1. That clear wins over a wrap in the same cycle.
- R4: When bit7 = 1, the block pauses while the synchronised gate equals bit2 (0 pauses on low, 1 pauses on high). While paused, events are ignored and `count_o` holds its value.
- R5: Control bits 4:3 select the source: 0 is the fast strobe, 1 is every 200th fast strobe (counted from reset), 2 is a rising edge of `ext_src`, and 3 is no source.
- R6: `ext_src`, `gate_in` and `updown_in` each pass through two flops. A level sampled at clock edge k acts on the update at edge k+2. An `ext_src` rise sampled at edge k produces a count at edge k+2.
- R7: In pulse mode (bit1 = 1) with arm set, `pulse_o` starts low after arming. It stays low for low-length events, then high for high-length events, and repeats. A length of 0 behaves as 1.
- R8: In pulse mode, a pause freezes both `pulse_o` and the position within the current phase.
- R9: While arm is clear, or in edge mode, `pulse_o` is low and the waveform restarts at the start of the low phase. With arm clear, `count_o` does not change except by a load.
- R10: Reset leaves `count_o` = 0, `tc_o` = 0, `pulse_o` = 0 and all configuration at 0.
- R11: A write to address 3 sets `count_o` to the written value at that edge. The load takes priority over a count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address |
| wr_data | input | 24 | Register write data |
| tick_fast | input | 1 | Fast timebase strobe, one cycle per tick |
| ext_src | input | 1 | Asynchronous external event input |
| gate_in | input | 1 | Asynchronous pause gate |
| updown_in | input | 1 | Asynchronous hardware direction line |
| count_o | output | 24 | Current count |
| tc_o | output | 1 | Sticky wrap flag |
| pulse_o | output | 1 | Pulse train output |

## Verification
Events from the fast strobe, the slow strobe, a register write or a load show up on `count_o`, `tc_o` and `pulse_o` immediately after the clock edge at which they are present. The gate and direction lines act two edges after they are sampled. An external edge is counted two edges after its rising level is first sampled.

The bench holds an event-level model that keeps its own sample history of the three asynchronous lines. At each rising edge, the model applies the configuration that was in force before that edge's write. It then compares all three outputs with the model at the following falling edge, every cycle, so each latency is checked exactly rather than within a window.

// File: rtl/pct_pkg.sv
package pct_pkg;
  // Control word, bits 7..0 (bit 8 is a write-only flag clear strobe)
  typedef struct packed {
    logic       gate_en;
    logic       dir_up;
    logic       dir_hw;
    logic [1:0] src;
    logic       pause_lvl;
    logic       mode;
    logic       arm;
  } ctrl_t;

  localparam int CLR_TC_BIT = 8;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_HIGH = 2'd1,
    A_LOW  = 2'd2,
    A_LOAD = 2'd3
  } addr_e;

  typedef enum logic [1:0] {
    SRC_FAST = 2'd0,
    SRC_SLOW = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_NONE = 2'd3
  } src_e;
endpackage

// File: rtl/pct_sync.sv
module pct_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/pct_src_sel.sv
module pct_src_sel
  import pct_pkg::*;
#(
  parameter int SLOW_DIV = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_fast,
  input  logic       ext_s,
  input  logic [1:0] sel,
  output logic       evt
);
  localparam int PW = $clog2(SLOW_DIV);

  logic [PW-1:0] pre;
  logic          ext_d;
  logic          slow_tick;
  logic          ext_edge;

  assign slow_tick = tick_fast && (pre == PW'(SLOW_DIV - 1));
  assign ext_edge  = ext_s & ~ext_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      ext_d <= 1'b0;
    end else begin
      ext_d <= ext_s;
      if (tick_fast) pre <= slow_tick ? '0 : pre + 1'b1;
    end
  end

  always_comb begin
    case (src_e'(sel))
      SRC_FAST: evt = tick_fast;
      SRC_SLOW: evt = slow_tick;
      SRC_EXT:  evt = ext_edge;
      default:  evt = 1'b0;
    endcase
  end

  // R5: a slow event only ever coincides with a fast strobe
  a_r5_slow_on_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_SLOW && evt) |-> tick_fast);
endmodule

// File: rtl/pct_edge_cnt.sv
module pct_edge_cnt #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         up,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr_tc,
  output logic [W-1:0] count,
  output logic         tc
);
  localparam logic [W-1:0] CMAX = '1;

  logic wrap;
  assign wrap = step && !load && (up ? (count == CMAX) : (count == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      tc    <= 1'b0;
    end else begin
      if (load)      count <= load_val;
      else if (step) count <= up ? count + 1'b1 : count - 1'b1;
      if (clr_tc)    tc <= 1'b0;
      else if (wrap) tc <= 1'b1;
    end
  end

  // R4 / R9: no step and no load leaves the count untouched
  a_r4_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(count));
  // R3: upward wrap lands on zero with the flag raised
  a_r3_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && up && count == CMAX && !clr_tc) |=> (count == '0 && tc));
  // R3: flag is sticky until cleared
  a_r3_tc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !clr_tc) |=> tc);
endmodule

// File: rtl/pct_pulse_gen.sv
module pct_pulse_gen #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic         step,
  input  logic [W-1:0] hi_len,
  input  logic [W-1:0] lo_len,
  output logic         pulse
);
  logic [W-1:0] el;
  logic [W:0]   nxt;
  logic [W-1:0] len;

  assign len = pulse ? hi_len : lo_len;
  assign nxt = {1'b0, el} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      el    <= '0;
    end else if (!arm) begin
      pulse <= 1'b0;
      el    <= '0;
    end else if (step) begin
      if (nxt >= {1'b0, len}) begin
        pulse <= ~pulse;
        el    <= '0;
      end else begin
        el <= nxt[W-1:0];
      end
    end
  end

  // R9: disarmed output drops to idle low
  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !pulse);
  // R8: no step while armed keeps the waveform frozen
  a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !step) |=> $stable(pulse));
endmodule

// File: rtl/pause_ctr_timer.sv
module pause_ctr_timer
  import pct_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int SLOW_DIV = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tick_fast,
  input  logic             ext_src,
  input  logic             gate_in,
  input  logic             updown_in,
  output logic [CNT_W-1:0] count_o,
  output logic             tc_o,
  output logic             pulse_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] hi_len, lo_len;
  logic [2:0]       async_s;
  logic             ext_s, gate_s, ud_s;
  logic             evt, paused, run, up, load, clr_tc;

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      hi_len <= '0;
      lo_len <= '0;
    end else if (wr_en) begin
      case (addr_e'(wr_addr))
        A_CTRL:  ctrl   <= ctrl_t'(wr_data[CTRL_W-1:0]);
        A_HIGH:  hi_len <= wr_data;
        A_LOW:   lo_len <= wr_data;
        default: ;
      endcase
    end
  end

  assign load   = wr_en && (addr_e'(wr_addr) == A_LOAD);
  assign clr_tc = wr_en && (addr_e'(wr_addr) == A_CTRL) && wr_data[CLR_TC_BIT];

  // R6: two-flop resynchronisation of the asynchronous lines
  pct_sync #(.W(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({updown_in, gate_in, ext_src}),
    .q    (async_s)
  );
  assign {ud_s, gate_s, ext_s} = async_s;

  pct_src_sel #(.SLOW_DIV(SLOW_DIV)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_fast(tick_fast),
    .ext_s    (ext_s),
    .sel      (ctrl.src),
    .evt      (evt)
  );

  assign paused = ctrl.gate_en && (gate_s == ctrl.pause_lvl);
  assign run    = ctrl.arm && !paused && evt;
  assign up     = ctrl.dir_hw ? ud_s : ctrl.dir_up;

  pct_edge_cnt #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (run && !ctrl.mode),
    .up      (up),
    .load    (load),
    .load_val(wr_data),
    .clr_tc  (clr_tc),
    .count   (count_o),
    .tc      (tc_o)
  );

  pct_pulse_gen #(.W(CNT_W)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (ctrl.arm && ctrl.mode),
    .step  (run && ctrl.mode),
    .hi_len(hi_len),
    .lo_len(lo_len),
    .pulse (pulse_o)
  );
endmodule

// File: tb/pause_ctr_timer_test.sv
module pause_ctr_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic        tick_fast = 1'b0;
  logic        ext_src = 1'b0;
  logic        gate_in = 1'b0;
  logic        updown_in = 1'b0;
  logic [23:0] count_o;
  logic        tc_o, pulse_o;

  int checks = 0, errors = 0;
  string cur_req = "R10";

  // stimulus generators
  int cyc_n = 0, fast_mode = 0, ext_per = 0, gate_per = 0, ud_per = 0;

  // reference model state
  logic [3:0]  eh = '0, gh = '0, uh = '0;
  logic [23:0] m_cnt = '0;
  bit          m_tc = 0, m_ph = 0;
  int          m_el = 0, m_pre = 0, m_hi = 0, m_lo = 0;
  bit          m_arm = 0, m_mode = 0, m_plv = 0, m_dhw = 0, m_dup = 0, m_gen = 0;
  int          m_src = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pause_ctr_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick_fast(tick_fast), .ext_src(ext_src), .gate_in(gate_in), .updown_in(updown_in),
    .count_o(count_o), .tc_o(tc_o), .pulse_o(pulse_o)
  );

  task automatic model_edge();
    bit ev, paused, up, run, load, wrap;
    int len;
    eh = {eh[2:0], ext_src};
    gh = {gh[2:0], gate_in};
    uh = {uh[2:0], updown_in};
    case (m_src)
      0: ev = tick_fast;
      1: ev = tick_fast && (m_pre == 199);
      2: ev = eh[2] && !eh[3];
      default: ev = 0;
    endcase
    if (tick_fast) m_pre = (m_pre == 199) ? 0 : m_pre + 1;
    paused = m_gen && (gh[2] == m_plv);
    up     = m_dhw ? uh[2] : m_dup;
    run    = m_arm && !paused && ev;
    load   = wr_en && wr_addr == 2'd3;
    wrap   = 0;
    if (load) m_cnt = wr_data;
    else if (run && !m_mode) begin
      wrap  = up ? (m_cnt == 24'hFFFFFF) : (m_cnt == 24'h0);
      m_cnt = up ? m_cnt + 24'd1 : m_cnt - 24'd1;
    end
    if (wr_en && wr_addr == 2'd0 && wr_data[8]) m_tc = 0;
    else if (wrap) m_tc = 1;
    if (!(m_arm && m_mode)) begin
      m_ph = 0; m_el = 0;
    end else if (run) begin
      len = m_ph ? m_hi : m_lo;
      if (m_el + 1 >= len) begin m_ph = !m_ph; m_el = 0; end
      else m_el = m_el + 1;
    end
    if (wr_en) begin
      case (wr_addr)
        2'd0: begin
          m_arm = wr_data[0]; m_mode = wr_data[1]; m_plv = wr_data[2];
          m_src = int'(wr_data[4:3]); m_dhw = wr_data[5]; m_dup = wr_data[6];
          m_gen = wr_data[7];
        end
        2'd1: m_hi = int'(wr_data);
        2'd2: m_lo = int'(wr_data);
        default: ;
      endcase
    end
  endtask

  task automatic compare();
    checks++;
    if (count_o !== m_cnt || tc_o !== m_tc || pulse_o !== m_ph) begin
      errors++;
      $display("FAIL %s cycle %0d: count=%h exp %h, tc=%b exp %b, pulse=%b exp %b",
               cur_req, cyc_n, count_o, m_cnt, tc_o, m_tc, pulse_o, m_ph);
    end
  endtask

  task automatic step_cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    cyc_n++;
    tick_fast = (fast_mode == 1) ? 1'b1 : (fast_mode == 2) ? (cyc_n % 3 == 0) : 1'b0;
    if (ext_per  != 0 && cyc_n % ext_per  == 0) ext_src   = ~ext_src;
    if (gate_per != 0 && cyc_n % gate_per == 0) gate_in   = ~gate_in;
    if (ud_per   != 0 && cyc_n % ud_per   == 0) updown_in = ~updown_in;
  endtask

  task automatic run_n(input int n);
    for (int i = 0; i < n; i++) step_cycle();
  endtask

  task automatic wr(input logic [1:0] a, input logic [23:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step_cycle();
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung, expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    run_n(4);

    // R1: count up on fast strobes, sparse pattern
    cur_req = "R1"; fast_mode = 2;
    wr(2'd0, 24'h41);
    run_n(30);
    // R11: load during counting
    cur_req = "R11";
    wr(2'd3, 24'h000005);
    run_n(5);
    // R2 + R3: count down through zero, wrap, sticky flag, then clear
    cur_req = "R3"; fast_mode = 1;
    wr(2'd0, 24'h01);
    run_n(12);
    wr(2'd0, 24'h101);
    run_n(3);
    cur_req = "R2";
    wr(2'd3, 24'hFFFFFD);
    wr(2'd0, 24'h41);
    run_n(6);
    // R2 + R6: hardware direction line
    cur_req = "R6"; ud_per = 5;
    wr(2'd0, 24'h121);
    run_n(40);
    ud_per = 0;
    // R4: pause on low, then pause on high
    cur_req = "R4"; gate_per = 7;
    wr(2'd0, 24'hC1);
    run_n(50);
    wr(2'd0, 24'hC5);
    run_n(50);
    gate_per = 0;
    // R5: slow source, every 200th fast strobe
    cur_req = "R5";
    wr(2'd0, 24'h49);
    run_n(1000);
    // R5 + R6: external edges, two spacings
    cur_req = "R6"; fast_mode = 0; ext_per = 3;
    wr(2'd0, 24'h51);
    run_n(40);
    ext_per = 1;
    run_n(20);
    ext_per = 0;
    // R5: no source selected
    cur_req = "R5"; fast_mode = 1;
    wr(2'd0, 24'h59);
    run_n(10);
    // R9: edge mode disarmed holds count
    cur_req = "R9";
    wr(2'd0, 24'h40);
    run_n(5);
    // R7: pulse train, high 3 low 2
    cur_req = "R7";
    wr(2'd1, 24'd3);
    wr(2'd2, 24'd2);
    wr(2'd0, 24'h03);
    run_n(40);
    fast_mode = 2;
    run_n(30);
    fast_mode = 1;
    wr(2'd1, 24'd0);
    wr(2'd2, 24'd0);
    run_n(10);
    // R8: pause freezes waveform
    cur_req = "R8";
    wr(2'd1, 24'd4);
    wr(2'd2, 24'd3);
    gate_per = 4;
    wr(2'd0, 24'h83);
    run_n(60);
    gate_per = 0;
    // R9: disarm returns output low, rearm restarts from low phase
    cur_req = "R9";
    wr(2'd0, 24'h03);
    run_n(5);
    wr(2'd0, 24'h02);
    run_n(5);
    wr(2'd0, 24'h03);
    run_n(20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule